// File: doc/BRIEF.md
# Retriggerable Resettable One-Shot Pulse Generator

This block is a clocked monostable for a single channel. When a qualified trigger event occurs, it drives its `q` output HIGH for a programmable number of clock cycles. The complementary output `q_n` is always the inverse of `q`. The pulse length is loaded from the `width` input. That loaded count stands in for the resistor and capacitor of an analog one-shot.

The block has two trigger pins, and each is gated by the level of the other:

- `trig_rise` responds to a rising edge, but only while `trig_fall` is HIGH.
- `trig_fall` responds to a falling edge, but only while `trig_rise` is LOW.

Both pins pass through a multi-flop synchroniser before edge detection, so they may be asynchronous to `clk`.

The `retrig` input selects the mode:

- In retriggerable mode, each accepted trigger reloads the full width.
- In lock-out mode, triggers are ignored while a pulse is running.

The active-low direct clear `clr_n` ends a pulse at once and blocks new pulses. It takes priority over a trigger event in the same clock cycle.

Top module: `pulse_oneshot`

## Requirements
- R1: A rising transition on `trig_rise` starts a pulse only if `trig_fall` is HIGH at that time. A falling transition on `trig_rise` never triggers.
- R2: A falling transition on `trig_fall` starts a pulse only if `trig_rise` is LOW at that time. A rising transition on `trig_fall` never triggers. When both pins change in the same cycle (rise 0→1, fall 1→0), neither qualifies.
- R3: With the default two synchroniser stages, trigger timing is as follows. A trigger level change sampled at clock edge k makes `q` rise after edge k+2. `q` then stays HIGH for exactly `width` cycles.
- R4: A trigger event that arrives while `width` is zero starts no pulse.
- R5: With `retrig`=1, a qualified trigger during a pulse reloads the full `width` from the cycle in which it is accepted.
- R6: With `retrig`=0, trigger events that arrive while `q` is HIGH are ignored. The pulse ends on its original schedule.
- R7: `q_n` is the inverse of `q` in every cycle.
- R8: Driving `clr_n` LOW forces `q` LOW in the same cycle, with no clock edge needed. The interrupted pulse does not resume when `clr_n` returns HIGH.
- R9: While `clr_n` is LOW, `q` stays LOW whatever the trigger pins do.
- R10: If `clr_n` is LOW at the clock edge where a trigger event would be accepted, no pulse starts. If `clr_n` has returned HIGH by that edge, the pulse starts.
- R11: After `rst_n` is released and before any trigger, `q` is LOW and `q_n` is HIGH.
- R12: Trigger levels already present when `rst_n` is released are not mistaken for edges. No pulse starts until a real transition is seen after the synchroniser has filled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of all state |
| clr_n | input | 1 | Active-low direct clear, synchronous to `clk` |
| retrig | input | 1 | 1 = retriggerable, 0 = lock-out |
| width | input | WIDTH | Pulse length in clock cycles, sampled when a pulse starts or restarts |
| trig_rise | input | 1 | Rising-edge trigger, qualified by `trig_fall` HIGH; may be asynchronous |
| trig_fall | input | 1 | Falling-edge trigger, qualified by `trig_rise` LOW; may be asynchronous |
| q | output | 1 | Pulse output, HIGH during the pulse |
| q_n | output | 1 | Complement of `q` |

## Verification
The assertions assume that `clr_n`, `retrig` and `width` are synchronous to `clk` and settled before each rising edge. Only the two trigger pins are allowed to be asynchronous, because only they are synchronised. The bench therefore changes every input on the falling clock edge, half a period away from any sampling edge. Between test cases the bench applies a short clear, so that no pulse carries over from one case into the next.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

   typedef enum logic {
      MODE_LOCKOUT = 1'b0,
      MODE_RETRIG  = 1'b1
   } oneshot_mode_e;

   typedef struct packed {
      logic rise_hit;
      logic fall_hit;
   } trig_hits_t;

   function automatic int unsigned prime_cycles(input int unsigned stages);
      return stages + 1;
   endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic d_sync
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/os_trig_qual.sv
module os_trig_qual
   import oneshot_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_s,
   input  logic fall_s,
   output logic trig
);
   localparam int unsigned PRIME = prime_cycles(STAGES);
   localparam int unsigned PW    = $clog2(PRIME + 1);

   logic          rise_prev, fall_prev;
   logic [PW-1:0] prime_cnt;
   logic          armed;
   trig_hits_t    hits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_prev <= 1'b0;
         fall_prev <= 1'b0;
         prime_cnt <= '0;
      end else begin
         rise_prev <= rise_s;
         fall_prev <= fall_s;
         if (!armed) prime_cnt <= prime_cnt + 1'b1;
      end
   end

   assign armed = (prime_cnt == PW'(PRIME));

   always_comb begin
      hits.rise_hit = rise_s & ~rise_prev & fall_s;
      hits.fall_hit = ~fall_s & fall_prev & ~rise_s;
   end

   assign trig = armed & (hits.rise_hit | hits.fall_hit);
endmodule

// File: rtl/os_timer.sv
module os_timer #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             trig,
   input  logic             retrig,
   input  logic [WIDTH-1:0] width,
   output logic [WIDTH-1:0] count,
   output logic             active
);
   logic accept;

   assign active = (count != '0);
   assign accept = trig && (width != '0) && (retrig || !active);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (!clr_n)   count <= '0;
      else if (accept)   count <= width;
      else if (active)   count <= count - 1'b1;
   end
endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot
   import oneshot_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             retrig,
   input  logic [WIDTH-1:0] width,
   input  logic             trig_rise,
   input  logic             trig_fall,
   output logic             q,
   output logic             q_n
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("pulse_oneshot: SYNC_STAGES must be at least 2");
      end
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("pulse_oneshot: WIDTH must be 1..32");
      end
   endgenerate

   logic             rise_s, fall_s;
   logic             trig_any;
   logic [WIDTH-1:0] cnt;
   logic             active;

   os_sync #(.STAGES(SYNC_STAGES)) u_sync_rise (
      .clk(clk), .rst_n(rst_n), .d_async(trig_rise), .d_sync(rise_s));

   os_sync #(.STAGES(SYNC_STAGES)) u_sync_fall (
      .clk(clk), .rst_n(rst_n), .d_async(trig_fall), .d_sync(fall_s));

   os_trig_qual #(.STAGES(SYNC_STAGES)) u_qual (
      .clk(clk), .rst_n(rst_n), .rise_s(rise_s), .fall_s(fall_s),
      .trig(trig_any));

   os_timer #(.WIDTH(WIDTH)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .trig(trig_any),
      .retrig(retrig), .width(width), .count(cnt), .active(active));

   assign q   = active & clr_n;
   assign q_n = ~q;
endmodule

// File: rtl/os_checker.sv
module os_checker #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_n,
   input logic             retrig,
   input logic [WIDTH-1:0] width,
   input logic             q,
   input logic             q_n,
   input logic [WIDTH-1:0] cnt,
   input logic             trig_any
);
   a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
      q_n != q);

   a_r8_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> !q);

   a_r9_clear_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> !q);

   a_r5_retrig_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && trig_any && retrig && width != '0) |=> cnt == $past(width));

   a_r6_lockout_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !retrig && cnt != '0) |=> cnt == $past(cnt) - WIDTH'(1));

   a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !trig_any && cnt != '0) |=> cnt == $past(cnt) - WIDTH'(1));

   a_r4_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && width == '0 && cnt == '0) |=> cnt == '0);
endmodule

bind pulse_oneshot os_checker #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .retrig(retrig), .width(width),
   .q(q), .q_n(q_n), .cnt(cnt), .trig_any(trig_any));

// File: tb/tb_pulse_oneshot.sv
module tb_pulse_oneshot;
   localparam int unsigned WIDTH = 8;
   localparam int NVEC = 10;

   // {rise_base, fall_base, rise_new, fall_new, width[7:0], expect_pulse, pad[2:0]}
   localparam logic [15:0] VEC [NVEC] = '{
      {1'b0, 1'b1, 1'b1, 1'b1, 8'd5,  1'b1, 3'd0},  // R1 qualified rise
      {1'b0, 1'b0, 1'b1, 1'b0, 8'd5,  1'b0, 3'd0},  // R1 rise, fall low
      {1'b0, 1'b1, 1'b0, 1'b0, 8'd3,  1'b1, 3'd0},  // R2 qualified fall
      {1'b1, 1'b1, 1'b1, 1'b0, 8'd3,  1'b0, 3'd0},  // R2 fall, rise high
      {1'b1, 1'b1, 1'b0, 1'b1, 8'd4,  1'b0, 3'd0},  // R1 falling rise pin
      {1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  1'b0, 3'd0},  // R2 rising fall pin
      {1'b0, 1'b1, 1'b1, 1'b1, 8'd1,  1'b1, 3'd0},  // R3 width one
      {1'b0, 1'b1, 1'b1, 1'b1, 8'd0,  1'b0, 3'd0},  // R4 width zero
      {1'b0, 1'b1, 1'b1, 1'b0, 8'd5,  1'b0, 3'd0},  // R2 both change
      {1'b0, 1'b1, 1'b0, 1'b0, 8'd12, 1'b1, 3'd0}   // R3 longer width
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr_n = 1'b1;
   logic             retrig = 1'b1;
   logic [WIDTH-1:0] width = '0;
   logic             trig_rise = 1'b1;
   logic             trig_fall = 1'b1;
   logic             q, q_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pulse_oneshot #(.WIDTH(WIDTH), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .retrig(retrig), .width(width),
      .trig_rise(trig_rise), .trig_fall(trig_fall), .q(q), .q_n(q_n));

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic count_high(input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         hi += int'(q);
      end
   endtask

   task automatic settle(input logic r, input logic f);
      @(negedge clk);
      trig_rise = r;
      trig_fall = f;
      repeat (5) @(negedge clk);
      clr_n = 1'b0;
      repeat (2) @(negedge clk);
      clr_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int hi;
      // R12: levels present at reset release (rise=1, fall=1)
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      width = 8'd6;
      #1;
      chk("R11 q low after reset", int'(q), 0);
      chk("R7 q_n high after reset", int'(q_n), 1);
      count_high(20, hi);
      chk("R12 no pulse from levels at reset release", hi, 0);

      // Vector table
      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] e;
         e = VEC[v];
         retrig = 1'b1;
         settle(e[15], e[14]);
         width = e[11:4];
         trig_rise = e[13];
         trig_fall = e[12];
         count_high(40, hi);
         chk($sformatf("R1/R2/R3/R4 vector %0d pulse length", v), hi,
             e[3] ? int'(e[11:4]) : 0);
      end

      // R3 latency: q low at second falling edge, high at third
      settle(1'b0, 1'b1);
      width = 8'd4;
      trig_rise = 1'b1;
      repeat (2) @(negedge clk);
      chk("R3 q still low before edge k+2", int'(q), 0);
      @(negedge clk);
      chk("R3 q high after edge k+2", int'(q), 1);
      chk("R7 q_n low during pulse", int'(q_n), 0);
      repeat (10) @(negedge clk);

      // R5 retrigger reloads full width: 4 + 6 = 10
      retrig = 1'b1;
      settle(1'b0, 1'b1);
      width = 8'd6;
      trig_fall = 1'b0;
      hi = 0;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         hi += int'(q);
         if (i == 2) trig_fall = 1'b1;
         if (i == 4) trig_fall = 1'b0;
      end
      chk("R5 retrigger total high", hi, 10);

      // R6 lock-out ignores second trigger
      retrig = 1'b0;
      settle(1'b0, 1'b1);
      width = 8'd6;
      trig_fall = 1'b0;
      hi = 0;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         hi += int'(q);
         if (i == 2) trig_fall = 1'b1;
         if (i == 4) trig_fall = 1'b0;
      end
      chk("R6 lock-out total high", hi, 6);
      retrig = 1'b1;

      // R8 clear mid-pulse acts at once and pulse does not resume
      settle(1'b0, 1'b1);
      width = 8'd10;
      trig_rise = 1'b1;
      hi = 0;
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk);
         if (i == 5) begin
            clr_n = 1'b0;
            #1;
            chk("R8 q low at once on clear", int'(q), 0);
            chk("R7 q_n high during clear", int'(q_n), 1);
         end else begin
            hi += int'(q);
         end
         if (i == 6) clr_n = 1'b1;
      end
      chk("R8 interrupted pulse high count", hi, 2);

      // R9 clear held low blocks triggers
      settle(1'b0, 1'b1);
      width = 8'd5;
      clr_n = 1'b0;
      trig_rise = 1'b1;
      count_high(10, hi);
      clr_n = 1'b1;
      begin
         int hi2;
         count_high(10, hi2);
         chk("R9 no pulse under held clear", hi + hi2, 0);
      end

      // R10 clear low at the accepting edge wins
      settle(1'b0, 1'b1);
      width = 8'd5;
      trig_rise = 1'b1;
      hi = 0;
      for (int i = 1; i <= 20; i++) begin
         @(negedge clk);
         hi += int'(q);
         if (i == 2) clr_n = 1'b0;
         if (i == 3) clr_n = 1'b1;
      end
      chk("R10 clear coincident with trigger blocks pulse", hi, 0);

      // R10 clear released before the accepting edge: trigger honoured
      settle(1'b0, 1'b1);
      width = 8'd5;
      clr_n = 1'b0;
      trig_rise = 1'b1;
      hi = 0;
      for (int i = 1; i <= 20; i++) begin
         @(negedge clk);
         if (i == 2) clr_n = 1'b1;
         else hi += int'(q);
      end
      chk("R10 trigger on clear release starts pulse", hi, 5);

      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (200000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
   end
endmodule